// File: doc/BRIEF.md
# Multi-phase clock generator

This block turns a fast system clock into slower derived clock waveforms. In two-phase operation it drives a clock and its exact complement. In four-phase operation it drives two non-overlapping clocks. Each of these is high for one quarter of the period, and both are low between them. A programmable count sets how many system clock cycles one phase lasts. Every derived output comes from a flip-flop, so no decode glitch reaches a clock pin.

The mode select and the phase length are sampled only at a period boundary. A change made partway through a period therefore never produces a truncated or stretched phase. The block has an asynchronous active-low reset whose release is synchronised inside. While reset is held all derived clocks are quiet, and the sequence restarts from the first phase once reset is released.

Top module: `phase_clock_gen`

## Requirements
- R1: While `rst_ni` is low, `clk_o`, `clk1_o` and `clk2_o` are 0 and `clk_n_o` is 1, and this holds at once when `rst_ni` falls in mid-run. After `rst_ni` rises, the outputs stay in that idle state through two rising edges of `clk_i`. The first phase appears after the third rising edge.
- R2: In two-phase mode (`four_phase_i` = 0), `clk_n_o` is always the inverse of `clk_o` once the first phase has begun.
- R3: In two-phase mode with phase length L, `clk_o` is high for L cycles and then low for L cycles, with period 2L, and it starts high. `clk1_o` and `clk2_o` stay 0.
- R4: In four-phase mode (`four_phase_i` = 1) with phase length L, the repeating sequence is `clk1_o` high for L cycles, both low for L, `clk2_o` high for L, and both low for L. `clk_o` stays 0 and `clk_n_o` stays 1.
- R5: `clk1_o` and `clk2_o` are never high in the same cycle.
- R6: The phase length L equals `ticks_i`, except that a value of 0 gives L = 1. With L = 1 the outputs change on every cycle.
- R7: A change of `ticks_i` during a period has no effect until that period ends. The new length applies from the first phase of the next period.
- R8: A change of `four_phase_i` during a period has no effect until that period ends. The new mode applies from the first phase of the next period.
- R9: The mode and length used for the first period after reset are the values on the inputs at the rising edge where the first phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one cycle is one time step |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| four_phase_i | input | 1 | 0 selects the complementary pair, 1 selects the non-overlapping quarter-duty pair |
| ticks_i | input | TICK_W (8) | Cycles per phase; 0 is treated as 1 |
| clk_o | output | 1 | Two-phase clock |
| clk_n_o | output | 1 | Complement of `clk_o` |
| clk1_o | output | 1 | First non-overlapping clock |
| clk2_o | output | 1 | Second non-overlapping clock |

## Verification
A wrong phase index or tick count shows up at the ports within one phase length, as an edge that arrives one or more cycles early or late. A configuration latched at the wrong moment shows up within the same period, as a period of mixed lengths or a mode switch in mid-sequence. The bench predicts every output in every cycle from elapsed time, mode and length. It sweeps both modes over a range of lengths that includes 0 and 1, and it makes mid-period changes of length and mode. Any such defect therefore produces a miscompare no later than the first phase where it matters.

// File: rtl/phclk_pkg.sv
`timescale 1ns/1ps
package phclk_pkg;

  typedef enum logic {
    MODE_TWO  = 1'b0,
    MODE_FOUR = 1'b1
  } phclk_mode_e;

  localparam int unsigned PH_W = 2;

  typedef logic [PH_W-1:0] phclk_ph_t;

  // Output bundle order: {clk, clk_n, clk1, clk2}
  typedef struct packed {
    logic clk;
    logic clk_n;
    logic clk1;
    logic clk2;
  } phclk_out_t;

  localparam phclk_out_t PHCLK_IDLE = '{clk: 1'b0, clk_n: 1'b1, clk1: 1'b0, clk2: 1'b0};

  function automatic phclk_ph_t phclk_last_ph(phclk_mode_e mode);
    return (mode == MODE_FOUR) ? phclk_ph_t'(3) : phclk_ph_t'(1);
  endfunction

  function automatic phclk_out_t phclk_decode(logic run, phclk_mode_e mode, phclk_ph_t ph);
    phclk_out_t o;
    o = PHCLK_IDLE;
    if (run) begin
      if (mode == MODE_TWO) begin
        o.clk   = (ph == phclk_ph_t'(0));
        o.clk_n = (ph != phclk_ph_t'(0));
      end else begin
        o.clk1 = (ph == phclk_ph_t'(0));
        o.clk2 = (ph == phclk_ph_t'(2));
      end
    end
    return o;
  endfunction

endpackage

// File: rtl/phclk_rst_sync.sv
`timescale 1ns/1ps
module phclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

  // Internal reset follows an asserted external reset on the same cycle
  p_assert_follows_r1: assert property (@(posedge clk_i) !rst_ni |-> !rst_sync_no);

endmodule

// File: rtl/phclk_tick_cnt.sv
`timescale 1ns/1ps
module phclk_tick_cnt #(
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [TICK_W-1:0] len_i,
  output logic              done_o
);

  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    done_o = run_i && (cnt_q == len_i - TICK_W'(1));
    cnt_en = run_i;
    if (done_o) cnt_d = '0;
    else        cnt_d = cnt_q + TICK_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Count never reaches the active length (length is never 0)
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_i));

endmodule

// File: rtl/phclk_phase_seq.sv
`timescale 1ns/1ps
module phclk_phase_seq
  import phclk_pkg::*;
#(
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phclk_mode_e       mode_i,
  input  logic [TICK_W-1:0] ticks_i,
  input  logic              done_i,
  output logic              run_o,
  output phclk_mode_e       mode_o,
  output logic [TICK_W-1:0] len_o,
  output logic              run_nxt_o,
  output phclk_mode_e       mode_nxt_o,
  output phclk_ph_t         ph_nxt_o
);

  logic              run_q, run_d;
  phclk_ph_t         ph_q, ph_d;
  phclk_mode_e       mode_q, mode_d;
  logic [TICK_W-1:0] len_q, len_d;
  logic              load;
  logic              at_last;

  always_comb begin
    run_d   = run_q;
    ph_d    = ph_q;
    mode_d  = mode_q;
    len_d   = len_q;
    load    = 1'b0;
    at_last = (ph_q == phclk_last_ph(mode_q));
    if (!run_q) begin
      run_d = 1'b1;
      ph_d  = '0;
      load  = 1'b1;
    end else if (done_i) begin
      if (at_last) begin
        ph_d = '0;
        load = 1'b1;
      end else begin
        ph_d = ph_q + phclk_ph_t'(1);
      end
    end
    if (load) begin
      mode_d = mode_i;
      len_d  = (ticks_i == '0) ? TICK_W'(1) : ticks_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      mode_q <= MODE_TWO;
      len_q  <= TICK_W'(1);
    end else begin
      run_q  <= run_d;
      ph_q   <= ph_d;
      mode_q <= mode_d;
      len_q  <= len_d;
    end
  end

  assign run_o      = run_q;
  assign mode_o     = mode_q;
  assign len_o      = len_q;
  assign run_nxt_o  = run_d;
  assign mode_nxt_o = mode_d;
  assign ph_nxt_o   = ph_d;

  // Configuration only moves at a period boundary
  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !(done_i && at_last)) |=> ($stable(len_q) && $stable(mode_q)));

  // Active length is never 0
  p_len_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (len_q != '0));

  // Two-phase operation only visits the first two phase slots
  p_ph_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && mode_q == MODE_TWO) |-> (ph_q <= phclk_ph_t'(1)));

  // Once running, the sequencer stays running until reset
  p_run_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);

endmodule

// File: rtl/phase_clock_gen.sv
`timescale 1ns/1ps
module phase_clock_gen
  import phclk_pkg::*;
#(
  parameter int unsigned TICK_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              four_phase_i,
  input  logic [TICK_W-1:0] ticks_i,
  output logic              clk_o,
  output logic              clk_n_o,
  output logic              clk1_o,
  output logic              clk2_o
);

  logic              rst_n_s;
  logic              done;
  logic              run;
  phclk_mode_e       mode;
  logic [TICK_W-1:0] len;
  logic              run_nxt;
  phclk_mode_e       mode_nxt;
  phclk_ph_t         ph_nxt;
  phclk_mode_e       mode_in;
  phclk_out_t        out_q, out_d;

  assign mode_in = four_phase_i ? MODE_FOUR : MODE_TWO;

  phclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  phclk_tick_cnt #(.TICK_W(TICK_W)) u_tick_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (run),
    .len_i  (len),
    .done_o (done)
  );

  phclk_phase_seq #(.TICK_W(TICK_W)) u_phase_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .mode_i     (mode_in),
    .ticks_i    (ticks_i),
    .done_i     (done),
    .run_o      (run),
    .mode_o     (mode),
    .len_o      (len),
    .run_nxt_o  (run_nxt),
    .mode_nxt_o (mode_nxt),
    .ph_nxt_o   (ph_nxt)
  );

  // Outputs are registered from the sequencer's next state so they stay
  // cycle-aligned with it and carry no decode glitches.
  always_comb out_d = phclk_decode(run_nxt, mode_nxt, ph_nxt);

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) out_q <= PHCLK_IDLE;
    else          out_q <= out_d;
  end

  assign clk_o   = out_q.clk;
  assign clk_n_o = out_q.clk_n;
  assign clk1_o  = out_q.clk1;
  assign clk2_o  = out_q.clk2;

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !(clk1_o && clk2_o));

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !run |-> (!clk_o && clk_n_o && !clk1_o && !clk2_o));

  p_complement_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (run && mode == MODE_TWO) |-> (clk_n_o == !clk_o));

  p_two_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (mode == MODE_TWO) |-> (!clk1_o && !clk2_o));

  p_four_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (run && mode == MODE_FOUR) |-> (!clk_o && clk_n_o));

endmodule

// File: tb/phase_clock_gen_test.sv
`timescale 1ns/1ps
module phase_clock_gen_test;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       four_phase_i;
  logic [7:0] ticks_i;
  logic       clk_o, clk_n_o, clk1_o, clk2_o;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  phase_clock_gen #(.TICK_W(8), .SYNC_STAGES(2)) uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .four_phase_i (four_phase_i),
    .ticks_i      (ticks_i),
    .clk_o        (clk_o),
    .clk_n_o      (clk_n_o),
    .clk1_o       (clk1_o),
    .clk2_o       (clk2_o)
  );

  function automatic logic [3:0] outs();
    return {clk_o, clk_n_o, clk1_o, clk2_o};
  endfunction

  function automatic int eff_len(int ticks);
    return (ticks == 0) ? 1 : ticks;
  endfunction

  function automatic int period(int mode, int ticks);
    return (mode != 0 ? 4 : 2) * eff_len(ticks);
  endfunction

  // Expected {clk, clk_n, clk1, clk2} at time t after the first phase starts
  function automatic logic [3:0] expect_v(int mode, int ticks, int t);
    int ph;
    if (t < 0) return 4'b0100;
    if (mode == 0) begin
      ph = (t / eff_len(ticks)) % 2;
      return (ph == 0) ? 4'b1000 : 4'b0100;
    end
    ph = (t / eff_len(ticks)) % 4;
    if (ph == 0) return 4'b0110;
    if (ph == 2) return 4'b0101;
    return 4'b0100;
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reset, start with (m0,k0), switch inputs to (m1,k1) at t=1, observe,
  // then drop reset in mid-run.
  task automatic run_seg(input int m0, input int k0, input int m1, input int k1,
                         input string tag);
    int p0, ncyc, t, mode_now;
    logic [3:0] e;
    p0   = period(m0, k0);
    ncyc = 3 + p0 + 2 * period(m1, k1) + 1;
    @(negedge clk_i);
    rst_ni       = 1'b0;
    four_phase_i = m0[0];
    ticks_i      = k0[7:0];
    @(negedge clk_i);
    check(outs(), 4'b0100, "R1 held in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      t = k - 3;
      if (t < p0) begin
        e = expect_v(m0, k0, t);
        mode_now = m0;
      end else begin
        e = expect_v(m1, k1, t - p0);
        mode_now = m1;
      end
      if (t < 0)       check(outs(), e, "R1 start latency");
      else if (t == 0) check(outs(), e, "R9 first phase");
      else             check(outs(), e, tag);
      check({3'b000, clk1_o & clk2_o}, 4'b0000, "R5 overlap");
      if (t >= 0 && mode_now == 0)
        check({3'b000, clk_n_o}, {3'b000, ~clk_o}, "R2 complement");
      if (t == 1) begin
        four_phase_i = m1[0];
        ticks_i      = k1[7:0];
      end
    end
    rst_ni = 1'b0;
    #1;
    check(outs(), 4'b0100, "R1 async reset");
  endtask

  initial begin
    rst_ni       = 1'b0;
    four_phase_i = 1'b0;
    ticks_i      = 8'd1;
    // Sweep of both modes over small phase lengths
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k <= 5; k++) begin
        if (k == 0)      run_seg(m, k, m, k, "R6 zero length");
        else if (m == 0) run_seg(m, k, m, k, "R3 two-phase");
        else             run_seg(m, k, m, k, "R4 four-phase");
      end
    end
    // Mid-period configuration changes
    run_seg(0, 3, 0, 1, "R7 length change");
    run_seg(1, 2, 1, 0, "R7 length change four");
    run_seg(0, 2, 1, 2, "R8 mode change");
    run_seg(1, 1, 0, 5, "R8 mode and length change");
    run_seg(0, 1, 0, 1, "R6 toggle every cycle");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule